// File: doc/BRIEF.md
# Serial ADC Result Port with Offset Correction

This block is the digital side of a serial analog-to-digital converter, written as synthesizable logic that runs on a system clock. The host lowers an active-low chip select. At that moment the block takes a 10-bit raw sample from an input port. It corrects the sample by a stored signed offset, clamps the result to the 10-bit range, and then sends it out serially. Each falling edge of the serial clock moves the output one bit further. The frame opens with two zero bits, then the result follows MSB first. After the twelfth falling edge the output stays low until the frame ends.

A frame can also refresh the stored offset. A long frame opens a calibration window. On the seventeenth falling edge the block takes a measured offset from an input port and holds it as pending. On the thirty-second falling edge it commits the pending value to the offset register and raises a one-clock done flag. A frame that ends before the thirty-second edge leaves the register unchanged. The serial side has no valid/ready back-pressure, because the host paces every bit with its own clock edges. The block never stalls the host. A sample that is not read out in full is discarded when chip select rises.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the output enable is low, the data output is low, the done flag is low and the stored offset is zero, so the first frame sends the raw sample unchanged.
- R2: The output enable goes high one clock after chip select is seen low, and goes low one clock after chip select is seen high. While the enable is low the data output is 0.
- R3: A frame starts on the clock where chip select is first seen low. The counter of falling edges is then zero and the output shows the first leading zero. After n counted falling edges (n from 1 to 11) the output shows frame bit n. Bits 0 and 1 are zeros, and bits 2 to 11 carry the result bits 9 down to 0.
- R4: From the twelfth counted falling edge until chip select rises, the data output is 0.
- R5: The raw sample is taken only when the frame starts. Later changes of the raw sample input do not change the bits sent in that frame.
- R6: The measured offset is taken on the seventeenth counted falling edge and committed on the thirty-second. The done flag is high for exactly the one clock that follows the commit.
- R7: A frame that ends with fewer than 32 counted falling edges leaves the stored offset unchanged and does not raise the done flag.
- R8: The result sent is the raw sample minus the stored offset, where the offset is an 8-bit two's complement value. The result is clamped to 0 if it falls below 0 and to 1023 if it rises above 1023.
- R9: The edge counter stops at 32. Further falling edges in the same frame cause no second commit and no done pulse, and the output stays 0.
- R10: Falling edges of the serial clock are ignored while chip select is high. A falling edge that arrives in the same clock as the start of a frame is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; its falling edges advance the frame |
| raw_sample | input | 10 | Unsigned converted sample, taken when a frame starts |
| meas_offset | input | 8 | Signed measured offset, taken on the seventeenth falling edge |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for the data pin; low means the pin floats |
| cal_done | output | 1 | One-clock pulse when the stored offset is committed |

## Verification
Two events can land in the same system clock: the start of a frame and a counted serial clock edge. The bench drives chip select low and the serial clock low in the same cycle, with a result whose bit 9 is 1. It then gives one more falling edge and checks the bits that follow. If the shared edge had been counted, bit 9 would appear one edge early, and the first two checks after the start would not both read zero. The bench also ends a frame right at the thirty-second edge, and ends another after thirty-one. It judges the done pulse and the offset applied to the next sample against its own model of the offset.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  // Where the frame stands, decoded from the falling-edge count.
  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } frame_phase_e;

  // Per-clock frame events produced at the top from the sampled pins.
  typedef struct packed {
    logic start;  // chip select seen falling: new frame
    logic tick;   // serial clock falling edge inside an open frame
  } frame_ev_t;

endpackage

// File: rtl/adc_sp_edge.sv
// Registers one synchronous pin and reports its falling edge.
module adc_sp_edge #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_q,
  output logic fall
);

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= RESET_LEVEL;
    else        level_q <= din;
  end

  assign fall = level_q & ~din;

endmodule

// File: rtl/adc_sp_frame_ctr.sv
// Counts serial falling edges in a frame, saturating at the calibration end.
module adc_sp_frame_ctr
  import adc_sp_pkg::*;
#(
  parameter int LEAD_BITS = 2,
  parameter int DATA_W    = 10,
  parameter int CAL_START = 17,
  parameter int CAL_END   = 32,
  localparam int CNT_W    = $clog2(CAL_END + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_ev_t        ev,
  output logic [CNT_W-1:0] cnt,
  output frame_phase_e     phase,
  output logic             cal_start,
  output logic             cal_end
);

  localparam int FRAME_BITS = LEAD_BITS + DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(CAL_END);
  localparam logic [CNT_W-1:0] CNT_LEAD   = CNT_W'(LEAD_BITS);
  localparam logic [CNT_W-1:0] CNT_FRAME  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OPEN   = CNT_W'(CAL_START - 1);
  localparam logic [CNT_W-1:0] CNT_CLOSE  = CNT_W'(CAL_END - 1);

  logic accept;

  assign accept = ev.tick && (cnt != CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (ev.start) cnt <= '0;
    else if (accept)   cnt <= cnt + 1'b1;
  end

  assign cal_start = accept && (cnt == CNT_OPEN);
  assign cal_end   = accept && (cnt == CNT_CLOSE);

  always_comb begin
    if (cnt < CNT_LEAD)       phase = PH_LEAD;
    else if (cnt < CNT_FRAME) phase = PH_DATA;
    else                      phase = PH_TAIL;
  end

endmodule

// File: rtl/adc_sp_ofs_store.sv
// Pending capture at the window open, commit at the window close.
module adc_sp_ofs_store
  import adc_sp_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_ev_t        ev,
  input  logic             cal_start,
  input  logic             cal_end,
  input  logic [OFS_W-1:0] meas_offset,
  output logic [OFS_W-1:0] ofs_q,
  output logic             done
);

  logic [OFS_W-1:0] pend_q;
  logic             pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (ev.start) begin
      pend_v <= 1'b0;
    end else if (cal_start) begin
      pend_q <= meas_offset;
      pend_v <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cal_end && pend_v) begin
        ofs_q <= pend_q;
        done  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_sp_shifter.sv
// Corrects and clamps the sample at frame start, then shifts it out MSB first.
module adc_sp_shifter
  import adc_sp_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LEAD_BITS = 2,
  parameter int OFS_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_ev_t         ev,
  input  frame_phase_e      phase,
  input  logic              oe,
  input  logic [DATA_W-1:0] raw,
  input  logic [OFS_W-1:0]  ofs,
  output logic              sdo
);

  localparam int FRAME_BITS = LEAD_BITS + DATA_W;
  localparam int EXT_W      = DATA_W + 2;

  logic signed [EXT_W-1:0] raw_x, ofs_x, diff;
  logic [DATA_W-1:0]       corr;
  logic [FRAME_BITS-1:0]   shreg;

  always_comb begin
    raw_x = $signed({2'b00, raw});
    ofs_x = $signed({{(EXT_W - OFS_W){ofs[OFS_W-1]}}, ofs});
    diff  = raw_x - ofs_x;
    if (diff[EXT_W-1])      corr = '0;
    else if (diff[EXT_W-2]) corr = '1;
    else                    corr = diff[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        shreg <= '0;
    else if (ev.start) shreg <= {{LEAD_BITS{1'b0}}, corr};
    else if (ev.tick)  shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
  end

  assign sdo = oe && (phase != PH_TAIL) && shreg[FRAME_BITS-1];

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LEAD_BITS = 2,
  parameter int OFS_W     = 8,
  parameter int CAL_START = 17,
  parameter int CAL_END   = 32,
  localparam int CNT_W    = $clog2(CAL_END + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] raw_sample,
  input  logic [OFS_W-1:0]  meas_offset,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              cal_done
);

  logic             cs_q, cs_fall;
  logic             sclk_q, sclk_fall;
  frame_ev_t        ev;
  logic [CNT_W-1:0] frame_cnt;
  frame_phase_e     phase;
  logic             cal_start, cal_end;
  logic [OFS_W-1:0] ofs_q;

  adc_sp_edge #(.RESET_LEVEL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .level_q(cs_q), .fall(cs_fall)
  );

  adc_sp_edge #(.RESET_LEVEL(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk), .level_q(sclk_q), .fall(sclk_fall)
  );

  // A serial edge counts only when the frame was already open last clock.
  assign ev.start = cs_fall;
  assign ev.tick  = sclk_fall && !cs_n && !cs_q;
  assign sdo_oe   = !cs_q;

  adc_sp_frame_ctr #(
    .LEAD_BITS(LEAD_BITS), .DATA_W(DATA_W),
    .CAL_START(CAL_START), .CAL_END(CAL_END)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(frame_cnt), .phase(phase),
    .cal_start(cal_start), .cal_end(cal_end)
  );

  adc_sp_ofs_store #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cal_start(cal_start),
    .cal_end(cal_end), .meas_offset(meas_offset), .ofs_q(ofs_q),
    .done(cal_done)
  );

  adc_sp_shifter #(
    .DATA_W(DATA_W), .LEAD_BITS(LEAD_BITS), .OFS_W(OFS_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .phase(phase), .oe(sdo_oe),
    .raw(raw_sample), .ofs(ofs_q), .sdo(sdo)
  );

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int DATA_W    = 10,
  parameter int LEAD_BITS = 2,
  parameter int OFS_W     = 8,
  parameter int CAL_END   = 32,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cs_q,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             cal_done,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [OFS_W-1:0] ofs_q
);

  localparam logic [CNT_W-1:0] TAIL_AT = CNT_W'(LEAD_BITS + DATA_W);
  localparam logic [CNT_W-1:0] END_AT  = CNT_W'(CAL_END);

  p_oe_tracks_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sdo_oe == !$past(cs_n)));

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !cs_n) |=> (frame_cnt == '0));

  p_tail_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && frame_cnt >= TAIL_AT) |-> !sdo);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (frame_cnt == END_AT));

  p_ofs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> $stable(ofs_q));

endmodule

bind adc_serial_port adc_serial_port_chk #(
  .DATA_W(DATA_W), .LEAD_BITS(LEAD_BITS), .OFS_W(OFS_W),
  .CAL_END(CAL_END), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_q(cs_q), .sdo(sdo),
  .sdo_oe(sdo_oe), .cal_done(cal_done), .frame_cnt(frame_cnt), .ofs_q(ofs_q)
);

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b1;
  logic [9:0] raw_sample = '0;
  logic [7:0] meas_offset = '0;
  logic       sdo, sdo_oe, cal_done;

  always #10 clk = ~clk;

  adc_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .raw_sample(raw_sample), .meas_offset(meas_offset),
    .sdo(sdo), .sdo_oe(sdo_oe), .cal_done(cal_done)
  );

  typedef struct {
    string req;
    int    what;  // 0 sdo, 1 sdo_oe, 2 cal_done
    int    val;
  } exp_t;

  exp_t  sb[$];
  event  mon_ev;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  int    exp_ofs = 0;
  int    pend_ofs = 0;
  logic [11:0] cur_word;

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      @(mon_ev);
      while (sb.size() > 0) begin
        exp_t e;
        int   act;
        e = sb.pop_front();
        act = (e.what == 0) ? int'(sdo) : (e.what == 1) ? int'(sdo_oe) : int'(cal_done);
        checks++;
        if (act != e.val) begin
          errors++;
          $display("FAIL %s %s actual=%0d expected=%0d at %0t", e.req,
                   (e.what == 0) ? "sdo" : (e.what == 1) ? "sdo_oe" : "cal_done",
                   act, e.val, $time);
        end
      end
    end
  end

  task automatic push(string r, int w, int v);
    exp_t e;
    e.req = r; e.what = w; e.val = v;
    sb.push_back(e);
  endtask

  task automatic fire();
    #2;
    -> mon_ev;
    #1;
  endtask

  function automatic int clampv(int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  // Check the port state after k counted falling edges of an open frame.
  task automatic check_edge(int k, string tag);
    int b;
    b = (k >= 12) ? 0 : int'(cur_word[11-k]);
    push((k >= 12) ? "R4" : tag, 0, b);
    push("R2", 1, 1);
    push((k == 32) ? "R6" : ((k > 32) ? "R9" : "R7"), 2, (k == 32) ? 1 : 0);
    fire();
  endtask

  task automatic check_idle(string tag);
    push(tag, 0, 0);
    push("R2", 1, 0);
    push(tag, 2, 0);
    fire();
  endtask

  // One frame: start (optionally with a shared serial edge), n edges, end.
  task automatic run_frame(int raw, int nedges, int ma, int mb, bit both, string tag);
    @(negedge clk);
    raw_sample  = 10'(raw);
    meas_offset = 8'(ma);
    cs_n = 1'b0;
    if (both) sclk = 1'b0;
    cur_word = {2'b00, 10'(clampv(raw - exp_ofs))};
    @(negedge clk);
    check_edge(0, tag);
    raw_sample = ~10'(raw);  // R5: late change must not reach the output
    sclk = 1'b1;
    for (int k = 1; k <= nedges; k++) begin
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
      if (k == 17) pend_ofs = ma;
      if (k == 32) exp_ofs = pend_ofs;
      check_edge(k, tag);
      sclk = 1'b1;
      if (k == 17) meas_offset = 8'(mb);
    end
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check_idle(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // R1: zero offset after reset, raw passes straight through
    run_frame(10'h2A5, 16, 0, 0, 1'b0, "R1");

    // R10: serial edges with chip select high are ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sclk = 1'b0;
      @(negedge clk); check_idle("R10");
      sclk = 1'b1;
    end

    // R6: full calibration frame commits the value seen at edge 17
    run_frame(10'h155, 32, 5, 77, 1'b0, "R5");
    run_frame(100, 12, 0, 0, 1'b0, "R8");          // 95
    // R7: short frame leaves the offset alone
    run_frame(10'h0F0, 31, 20, 20, 1'b0, "R7");
    run_frame(100, 12, 0, 0, 1'b0, "R7");          // still 95
    run_frame(3, 12, 0, 0, 1'b0, "R8");            // clamps to 0
    // R9: edges past 32 give one pulse, sdo stays low
    run_frame(10'h200, 40, -7, 3, 1'b0, "R9");
    run_frame(1020, 12, 0, 0, 1'b0, "R8");         // clamps to 1023
    run_frame(500, 12, 0, 0, 1'b0, "R8");          // 507
    // R10: shared start and serial edge; the edge is not counted
    run_frame(10'h300, 12, 0, 0, 1'b1, "R10");

    // R3: aborted frame, then a new frame restarts at bit 0
    @(negedge clk); raw_sample = 10'h3FF; cs_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sclk = 1'b0;
      @(negedge clk); sclk = 1'b1;
    end
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); check_idle("R3");
    run_frame(10'h0AA, 14, 0, 0, 1'b0, "R3");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule